// File: doc/BRIEF.md
# Packet Buffer Network Interface Front End

This block is the host-facing side of a minimal network interface. The host sees one byte-addressed packet buffer, a length register, a command register and a status word, all through a simple read/write register port. The buffer holds either the packet about to go out or the packet just taken in. A send command streams the first `length` bytes of the buffer onto an outbound byte stream with valid, ready and last. A receive command moves the oldest packet from a small inbound holding queue into the buffer.

Inbound packets arrive on a byte stream with valid and last and no backpressure. They are held in a queue of `RX_SLOTS` packets, each up to `RX_MAX` bytes. A packet that begins while the queue is full is discarded whole. The interrupt line follows a two-bit status word that the host clears by reading it. One bit reports that the last receive delivered a packet. The other reports that further packets are still waiting in the queue.

Top module: `netif_frontend`

## Requirements
- R1: Offsets 0x0000 up to BUF_BYTES-1 each hold one byte; a write stores the low 8 bits of `host_wdata`, a read returns the byte zero-extended. Offsets from BUF_BYTES up to 0x3fff read 0 and ignore writes. Every read answers in the cycle after the request with `host_rvalid` high.
- R2: Offset 0x4010 holds the packet length. The host can read and write it, and a written value larger than BUF_BYTES is stored as BUF_BYTES.
- R3: Offset 0x4000 is the status word. Bit 0 means the last receive delivered a packet, and bit 1 means packets were still waiting when that receive finished. `irq` is high exactly while the status word is nonzero.
- R4: Reading the status word returns its value and clears it, which drops `irq`. A status bit set in the same cycle as the read survives the read, so it is reported by the next read.
- R5: Writing 1 to offset 0x4020 sends buffer bytes 0 to length-1 in order on `tx_data`, with `tx_last` only on the final byte. A byte is held stable while `tx_ready` is low. A length of 0 sends nothing. Command values other than 0 and 1 do nothing.
- R6: Writing 0 to offset 0x4020 while a packet is queued does four things. It copies the oldest packet into the buffer from offset 0, sets the length to its size, sets status bit 0, and also sets bit 1 if another packet remains queued.
- R7: A receive command with the queue empty leaves the buffer untouched, sets the length to 0 and sets no status bit.
- R8: `busy` is high from an accepted send or non-empty receive until its transfer ends. While busy, writes to the command, length and buffer offsets are ignored, and buffer reads return 0. Send leaves the status word unchanged.
- R9: The queue holds RX_SLOTS packets in arrival order. A packet whose first byte arrives while the queue is full is dropped entirely. Bytes past RX_MAX in one packet are discarded, so that packet's length is RX_MAX.
- R10: After reset `irq`, `busy`, `tx_valid` and `host_rvalid` are low, the status word is 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 15 | Host byte offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after host_rd |
| irq | output | 1 | Interrupt, high while the status word is nonzero |
| busy | output | 1 | Transfer in progress |
| tx_data | output | 8 | Outbound byte |
| tx_valid | output | 1 | Outbound byte valid |
| tx_last | output | 1 | Outbound byte is the last of the packet |
| tx_ready | input | 1 | Outbound sink accepts the byte |
| rx_data | input | 8 | Inbound byte |
| rx_valid | input | 1 | Inbound byte valid |
| rx_last | input | 1 | Inbound byte ends its packet |

## Verification
Two things can land on the status word in the same cycle: the host's clearing read and the completion of a receive copy, which sets bit 0. To force the collision, the bench issues a receive and then reads the status word on every cycle until the copy has finished, so one of those reads falls exactly on the completion cycle. It then makes one final read. The outcome is judged by counting how often bit 0 was seen across all the reads. It must appear exactly once: a count of zero means the set was lost under the clear, and a count of two means the read failed to clear it.

// File: rtl/netif_pkg.sv
package netif_pkg;
  localparam int HOST_AW = 15;
  localparam int HOST_DW = 16;

  localparam logic [HOST_AW-1:0] OFF_STATUS = 15'h4000;
  localparam logic [HOST_AW-1:0] OFF_LENGTH = 15'h4010;
  localparam logic [HOST_AW-1:0] OFF_CMD    = 15'h4020;

  localparam logic [HOST_DW-1:0] CMD_RECV = 16'h0000;
  localparam logic [HOST_DW-1:0] CMD_SEND = 16'h0001;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_TX_FETCH,
    ENG_TX_LOAD,
    ENG_TX_HOLD,
    ENG_RX_READ,
    ENG_RX_WRITE
  } eng_state_t;
endpackage

// File: rtl/netif_bufram.sv
// Single-port byte RAM, read-first, registered output (block RAM friendly).
module netif_bufram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/netif_rxqueue.sv
// Inbound packet holding queue. SLOTS and MAXB must be powers of two, SLOTS >= 2.
module netif_rxqueue #(
  parameter int SLOTS = 2,
  parameter int MAXB  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [7:0]                 in_data,
  input  logic                       in_last,
  input  logic                       pop,
  input  logic [$clog2(MAXB)-1:0]    rd_off,
  output logic [7:0]                 rd_data,
  output logic [$clog2(MAXB+1)-1:0]  head_len,
  output logic [$clog2(SLOTS+1)-1:0] count
);
  localparam int SW = $clog2(SLOTS);
  localparam int BW = $clog2(MAXB);
  localparam int LW = $clog2(MAXB+1);
  localparam int CW = $clog2(SLOTS+1);

  logic [7:0]    mem  [SLOTS*MAXB];
  logic [LW-1:0] lens [SLOTS];

  logic [SW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] fill;
  logic          in_pkt, dropping;

  logic          start, drop_now, store, commit, pop_ok;
  logic [LW-1:0] fill_next;

  always_comb begin
    start     = in_valid && !in_pkt;
    drop_now  = start ? (cnt_q == CW'(SLOTS)) : dropping;
    store     = in_valid && !drop_now && (fill < LW'(MAXB));
    fill_next = store ? fill + 1'b1 : fill;
    commit    = in_valid && in_last && !drop_now;
    pop_ok    = pop && (cnt_q != '0);
  end

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (store)  mem[{wr_ptr, fill[BW-1:0]}] <= in_data;
    if (commit) lens[wr_ptr] <= fill_next;
    rd_data <= mem[{rd_ptr, rd_off}];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt_q    <= '0;
      fill     <= '0;
      in_pkt   <= 1'b0;
      dropping <= 1'b0;
    end else begin
      if (in_valid) begin
        if (in_last) begin
          in_pkt   <= 1'b0;
          dropping <= 1'b0;
          fill     <= '0;
          if (commit) wr_ptr <= wr_ptr + 1'b1;
        end else begin
          in_pkt   <= 1'b1;
          dropping <= drop_now;
          fill     <= fill_next;
        end
      end
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      cnt_q <= cnt_q + CW'(commit) - CW'(pop_ok);
    end
  end

  assign head_len = lens[rd_ptr];
  assign count    = cnt_q;
endmodule

// File: rtl/netif_frontend.sv
module netif_frontend
  import netif_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int RX_SLOTS  = 2,
  parameter int RX_MAX    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [14:0] host_addr,
  input  logic [15:0] host_wdata,
  output logic [15:0] host_rdata,
  output logic        host_rvalid,
  output logic        irq,
  output logic        busy,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  output logic        tx_last,
  input  logic        tx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_valid,
  input  logic        rx_last
);
  localparam int BAW   = $clog2(BUF_BYTES);
  localparam int LEN_W = $clog2(BUF_BYTES+1);
  localparam int RBW   = $clog2(RX_MAX);
  localparam int RLW   = $clog2(RX_MAX+1);
  localparam int RCW   = $clog2(RX_SLOTS+1);

  eng_state_t       state;
  logic [LEN_W-1:0] idx, len_q;
  logic [RLW-1:0]   copy_len;
  logic [1:0]       stat_q, stat_set;
  logic [15:0]      rd_reg;
  logic             rd_from_ram;

  logic             idle, in_buf, hit_stat, hit_len, hit_cmd;
  logic             cmd_wr, start_tx, start_rx, rx_final, q_pop;
  logic             ram_we;
  logic [BAW-1:0]   ram_addr;
  logic [7:0]       ram_wd, ram_q, q_rdata;
  logic [RLW-1:0]   q_head_len;
  logic [RCW-1:0]   q_count;

  always_comb begin
    idle     = (state == ENG_IDLE);
    in_buf   = host_addr < 15'(BUF_BYTES);
    hit_stat = host_addr == OFF_STATUS;
    hit_len  = host_addr == OFF_LENGTH;
    hit_cmd  = host_addr == OFF_CMD;
    cmd_wr   = host_wr && hit_cmd && idle;
    start_tx = cmd_wr && (host_wdata == CMD_SEND);
    start_rx = cmd_wr && (host_wdata == CMD_RECV);
    rx_final = (state == ENG_RX_WRITE) && (idx == LEN_W'(copy_len) - 1'b1);
    q_pop    = rx_final;
    stat_set = rx_final ? {q_count > RCW'(1), 1'b1} : 2'b00;
  end

  always_comb begin
    ram_we   = idle && host_wr && in_buf;
    ram_addr = idle ? host_addr[BAW-1:0] : idx[BAW-1:0];
    ram_wd   = host_wdata[7:0];
    if (state == ENG_RX_WRITE) begin
      ram_we = 1'b1;
      ram_wd = q_rdata;
    end
  end

  netif_bufram #(.DEPTH(BUF_BYTES), .AW(BAW)) u_buf (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wd), .rdata(ram_q)
  );

  netif_rxqueue #(.SLOTS(RX_SLOTS), .MAXB(RX_MAX)) u_rxq (
    .clk(clk), .rst(rst),
    .in_valid(rx_valid), .in_data(rx_data), .in_last(rx_last),
    .pop(q_pop), .rd_off(idx[RBW-1:0]), .rd_data(q_rdata),
    .head_len(q_head_len), .count(q_count)
  );

  // transfer engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ENG_IDLE;
      idx      <= '0;
      copy_len <= '0;
      len_q    <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      tx_last  <= 1'b0;
    end else begin
      unique case (state)
        ENG_IDLE: begin
          if (host_wr && hit_len)
            len_q <= (host_wdata > 16'(BUF_BYTES)) ? LEN_W'(BUF_BYTES) : host_wdata[LEN_W-1:0];
          idx <= '0;
          if (start_tx && len_q != '0) state <= ENG_TX_FETCH;
          if (start_rx) begin
            if (q_count == '0) len_q <= '0;
            else begin
              copy_len <= q_head_len;
              state    <= ENG_RX_READ;
            end
          end
        end
        ENG_TX_FETCH: state <= ENG_TX_LOAD;
        ENG_TX_LOAD: begin
          tx_data  <= ram_q;
          tx_valid <= 1'b1;
          tx_last  <= (idx == len_q - 1'b1);
          state    <= ENG_TX_HOLD;
        end
        ENG_TX_HOLD: begin
          if (tx_ready) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            if (idx == len_q - 1'b1) state <= ENG_IDLE;
            else begin
              idx   <= idx + 1'b1;
              state <= ENG_TX_FETCH;
            end
          end
        end
        ENG_RX_READ: state <= ENG_RX_WRITE;
        ENG_RX_WRITE: begin
          if (rx_final) begin
            len_q <= LEN_W'(copy_len);
            state <= ENG_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= ENG_RX_READ;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // status word and host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q      <= '0;
      rd_reg      <= '0;
      rd_from_ram <= 1'b0;
      host_rvalid <= 1'b0;
    end else begin
      stat_q      <= ((host_rd && hit_stat) ? 2'b00 : stat_q) | stat_set;
      host_rvalid <= host_rd;
      rd_from_ram <= host_rd && in_buf && idle;
      if (hit_stat)     rd_reg <= {14'd0, stat_q};
      else if (hit_len) rd_reg <= 16'(len_q);
      else              rd_reg <= '0;
    end
  end

  assign host_rdata = rd_from_ram ? {8'd0, ram_q} : rd_reg;
  assign irq        = (stat_q != 2'b00);
  assign busy       = !idle;
endmodule

// File: rtl/netif_frontend_chk.sv
module netif_frontend_chk
  import netif_pkg::*;
#(
  parameter int BUF_BYTES = 2048,
  parameter int LEN_W     = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             host_wr,
  input logic             host_rd,
  input logic [14:0]      host_addr,
  input logic [15:0]      host_wdata,
  input logic             host_rvalid,
  input logic             irq,
  input logic             busy,
  input logic [7:0]       tx_data,
  input logic             tx_valid,
  input logic             tx_last,
  input logic             tx_ready,
  input logic [LEN_W-1:0] len_q
);
  p_tx_hold_r5: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

  p_send_starts_r5: assert property (@(posedge clk) disable iff (rst)
    !busy && host_wr && host_addr == OFF_CMD && host_wdata == CMD_SEND && len_q != '0 |=> busy);

  p_len_clamp_r2: assert property (@(posedge clk) disable iff (rst)
    32'(len_q) <= BUF_BYTES);

  p_status_clear_r4: assert property (@(posedge clk) disable iff (rst)
    host_rd && host_addr == OFF_STATUS && !busy |=> !irq);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);

  p_read_answer_r1: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
endmodule

bind netif_frontend netif_frontend_chk #(.BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rvalid(host_rvalid),
  .irq(irq), .busy(busy), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_ready(tx_ready), .len_q(len_q)
);

// File: tb/tb_netif_frontend.sv
module tb_netif_frontend;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [14:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rvalid, irq, busy;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_last;
  logic        tx_ready = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0, rx_last = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  netif_frontend #(.BUF_BYTES(2048), .RX_SLOTS(2), .RX_MAX(16)) dut (.*);

  // {write, offset, data-or-expected}
  localparam logic [31:0] VEC [14] = '{
    {1'b1, 15'h0000, 16'h00A5}, {1'b1, 15'h0001, 16'h123C},
    {1'b1, 15'h07FF, 16'h0077}, {1'b1, 15'h0800, 16'h0099},
    {1'b0, 15'h0000, 16'h00A5}, {1'b0, 15'h0001, 16'h003C},
    {1'b0, 15'h07FF, 16'h0077}, {1'b0, 15'h0800, 16'h0000},
    {1'b0, 15'h3FFF, 16'h0000}, {1'b1, 15'h4010, 16'h0005},
    {1'b0, 15'h4010, 16'h0005}, {1'b1, 15'h4010, 16'h2000},
    {1'b0, 15'h4010, 16'h0800}, {1'b0, 15'h4000, 16'h0000}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [14:0] a, input logic [15:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [14:0] a, output int d);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    @(negedge clk); host_rd = 1'b0;
    d = host_rvalid ? int'(host_rdata) : -1;
  endtask

  task automatic rx_pkt(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = 8'(base + i); rx_last = (i == n-1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v;
    int got[$];
    int lastcnt;
    int seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 busy", busy, 0);
    chk("R10 tx_valid", tx_valid, 0);
    chk("R10 rvalid", host_rvalid, 0);

    // table walk: R1 buffer window, R2 length clamp, R3 status idle
    for (int i = 0; i < 14; i++) begin
      if (VEC[i][31]) hwr(VEC[i][30:16], VEC[i][15:0]);
      else begin
        hrd(VEC[i][30:16], v);
        if (VEC[i][30:16] < 15'h4000) chk("R1 buffer read", v, int'(VEC[i][15:0]));
        else if (VEC[i][30:16] == 15'h4010) chk("R2 length read", v, int'(VEC[i][15:0]));
        else chk("R3 status read", v, int'(VEC[i][15:0]));
      end
    end

    // R5 send four bytes, ready toggling
    for (int i = 0; i < 4; i++) hwr(15'(i), 16'(8'h11 * (i + 1)));
    hwr(15'h4010, 16'd4);
    hwr(15'h4020, 16'd1);
    got.delete(); lastcnt = 0;
    for (int c = 0; c < 200 && (busy || tx_valid); c++) begin
      @(negedge clk);
      tx_ready = c[0];
      if (tx_valid && tx_ready) begin
        got.push_back(int'(tx_data));
        if (tx_last) lastcnt += (got.size() == 4) ? 1 : 100;
      end
    end
    tx_ready = 1'b0;
    chk("R5 byte count", got.size(), 4);
    for (int i = 0; i < 4 && i < got.size(); i++) chk("R5 byte order", got[i], 8'h11 * (i + 1));
    chk("R5 last only on final", lastcnt, 1);
    chk("R8 send sets no status", irq, 0);

    // R5 zero length and unknown command
    hwr(15'h4010, 16'd0);
    hwr(15'h4020, 16'd1);
    seen = 0;
    repeat (10) begin @(negedge clk); seen += int'(tx_valid) + int'(busy); end
    hwr(15'h4010, 16'd3);
    hwr(15'h4020, 16'd7);
    repeat (10) begin @(negedge clk); seen += int'(tx_valid) + int'(busy); end
    chk("R5 len0/unknown cmd silent", seen, 0);

    // R7 receive with empty queue
    hwr(15'h0000, 16'h005A);
    hwr(15'h4020, 16'd0);
    wait_idle();
    hrd(15'h4010, v); chk("R7 length zero", v, 0);
    hrd(15'h0000, v); chk("R7 buffer untouched", v, 16'h5A);
    chk("R7 no status", irq, 0);

    // R6 one packet
    rx_pkt(3, 1);
    hwr(15'h4020, 16'd0);
    wait_idle();
    chk("R3 irq on status", irq, 1);
    hrd(15'h4000, v); chk("R6 status delivered", v, 1);
    chk("R4 irq cleared by read", irq, 0);
    hrd(15'h4010, v); chk("R6 length", v, 3);
    for (int i = 0; i < 3; i++) begin hrd(15'(i), v); chk("R6 copied byte", v, i + 1); end

    // R9 queue full drop, R6 more-waiting bit
    rx_pkt(2, 8'h20);
    rx_pkt(3, 8'h30);
    rx_pkt(1, 8'h40);
    hwr(15'h4020, 16'd0); wait_idle();
    hrd(15'h4000, v); chk("R6 status more waiting", v, 3);
    hrd(15'h4010, v); chk("R9 first length", v, 2);
    hwr(15'h4020, 16'd0); wait_idle();
    hrd(15'h4000, v); chk("R6 status last one", v, 1);
    hrd(15'h0002, v); chk("R9 order second packet", v, 8'h32);
    hwr(15'h4020, 16'd0); wait_idle();
    hrd(15'h4010, v); chk("R9 dropped when full", v, 0);

    // R9 truncation at RX_MAX
    hwr(15'h0010, 16'h00EE);
    rx_pkt(20, 8'h40);
    hwr(15'h4020, 16'd0); wait_idle();
    hrd(15'h4010, v); chk("R9 clamp length", v, 16);
    hrd(15'h000F, v); chk("R9 last kept byte", v, 8'h4F);
    hrd(15'h0010, v); chk("R9 byte past max discarded", v, 8'hEE);
    hrd(15'h4000, v);

    // R8 writes ignored while busy
    rx_pkt(1, 8'h99);
    hwr(15'h0000, 16'h0061); hwr(15'h0001, 16'h0062);
    hwr(15'h4010, 16'd2);
    tx_ready = 1'b0;
    hwr(15'h4020, 16'd1);
    repeat (4) @(negedge clk);
    chk("R5 byte held while not ready", tx_valid, 1);
    hwr(15'h4020, 16'd0);
    hwr(15'h4010, 16'd7);
    hwr(15'h0001, 16'h00FF);
    hrd(15'h0000, v); chk("R8 buffer read while busy", v, 0);
    tx_ready = 1'b1;
    wait_idle();
    @(negedge clk); tx_ready = 1'b0;
    hrd(15'h4010, v); chk("R8 length write ignored", v, 2);
    hrd(15'h4000, v); chk("R8 receive ignored while busy", v, 0);
    hrd(15'h0001, v); chk("R8 buffer write ignored", v, 8'h62);
    hwr(15'h4020, 16'd0); wait_idle();
    hrd(15'h0000, v); chk("R8 queued packet kept", v, 8'h99);

    // R4 status read coinciding with receive completion
    hrd(15'h4000, v);
    rx_pkt(4, 8'h70);
    @(negedge clk); host_wr = 1'b1; host_addr = 15'h4020; host_wdata = 16'd0;
    @(negedge clk); host_wr = 1'b0; host_rd = 1'b1; host_addr = 15'h4000;
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (host_rvalid && host_rdata[0]) seen++;
      if (!busy && c > 3) break;
    end
    @(negedge clk); host_rd = 1'b0;
    if (host_rvalid && host_rdata[0]) seen++;
    hrd(15'h4000, v);
    if (v[0]) seen++;
    chk("R4 set during read reported once", seen, 1);
    chk("R4 irq low after reads", irq, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule